// File: doc/BRIEF.md
# Reset and Low-Power Mode Controller

This block turns the raw oscillator clock and an asynchronous external reset pin into the timing and control signals of a small 8-bit controller core. It derives a machine-cycle strobe (one per twelve input clocks) from a divide-by-two phase. It filters the reset pin so that only a pin held high for two whole machine cycles resets the core. It also runs the two software-requested low-power modes.

Idle mode stops only the CPU clock. Timers, serial logic and interrupt logic keep running, and an enabled interrupt or the reset pin ends idle. Power-down stops the oscillator, and only the reset pin ends it. The core is then held in reset for a programmable settling time while the oscillator restarts. A reset that ends idle lets the CPU run until qualification completes, with RAM writes blocked so that memory survives. Port outputs are forced high the moment the pin rises.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: `mc_stb_o` is high for exactly one clock in every 12 clocks while the oscillator is enabled.
- R2: `core_rst_o` rises 26 clocks after the pin is raised, that is, 2 synchroniser clocks plus 24 clocks of pin high. A pin pulse shorter than that causes no core reset. Core reset clears 3 clocks after the pin falls.
- R3: `port_ones_o` is high at once, without any clock edge, whenever `rst_pin_i` is high, and it stays high for the whole core reset.
- R4: The clock after `idle_req_i` is sampled in run mode, `cpu_clk_en_o`=0, `per_clk_en_o`=1 and `osc_en_o`=1.
- R5: In idle, `wake_irq_i` sampled high returns the block to run (`cpu_clk_en_o`=1) on the next clock.
- R6: The clock after `pd_req_i` is sampled in run mode, `osc_en_o`, `cpu_clk_en_o` and `per_clk_en_o` are all 0. No strobe appears, and `wake_irq_i` has no effect.
- R7: Power-down ends only through the pin. Three clocks after the pin rises, `osc_en_o`=1 and `core_rst_o`=1. Core reset then stays high for STAB_CLKS clocks even if the pin is released, after which the block returns to run.
- R8: A synchronised pin seen in idle returns the CPU clock on the next clock with `ram_wr_inhibit_o`=1 and `core_rst_o` still 0. Inhibit stays high through the core reset and clears when core reset ends.
- R9: When `idle_req_i` and `pd_req_i` are both sampled high in run mode, power-down is entered.
- R10: Mode requests are ignored while the synchronised pin is high or core reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| idle_req_i | input | 1 | Software request to enter idle |
| pd_req_i | input | 1 | Software request to enter power-down |
| wake_irq_i | input | 1 | Any enabled interrupt pending |
| mc_stb_o | output | 1 | One-clock machine-cycle strobe |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| core_rst_o | output | 1 | Qualified synchronous core reset |
| port_ones_o | output | 1 | Force port outputs to all ones |
| ram_wr_inhibit_o | output | 1 | Block RAM writes |

## Verification
A wrong mode state appears at the clock enables on the very next clock. A run/idle mix-up shows as the wrong `cpu_clk_en_o`, and a lost power-down shows as `osc_en_o` still high. A qualification counter that is off by any count moves the `core_rst_o` edge away from clock 26, which the bench samples on both sides. A stuck settling counter either releases reset before STAB_CLKS or never releases it. A broken phase counter changes the strobe gap from 12 within one machine cycle.

// File: rtl/pr_pkg.sv
`timescale 1ns/1ps
package pr_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PD   = 2'd2,
    MODE_STAB = 2'd3
  } pr_mode_e;
endpackage

// File: rtl/pr_sync.sv
`timescale 1ns/1ps
module pr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pr_mcycle.sv
`timescale 1ns/1ps
module pr_mcycle #(
  parameter int OSC_PER_MC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic stb_o
);
  localparam int HALF = OSC_PER_MC / 2;
  localparam int PW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] LAST = PW'(HALF - 1);

  logic          div_q;
  logic [PW-1:0] ph_q;

  // divide-by-two phase makes input duty cycle irrelevant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 1'b0;
      ph_q  <= '0;
    end else if (run_i) begin
      div_q <= ~div_q;
      if (div_q) ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
  end

  assign stb_o = run_i & div_q & (ph_q == LAST);
endmodule

// File: rtl/pr_rst_qual.sv
`timescale 1ns/1ps
module pr_rst_qual #(
  parameter int LIMIT = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pin_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!pin_i)                    cnt_q <= '0;
    else if (run_i && (cnt_q != LIM))   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/pr_mode_fsm.sv
`timescale 1ns/1ps
module pr_mode_fsm
  import pr_pkg::*;
#(
  parameter int STAB_CLKS = 64
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rst_sync_i,
  input  logic     idle_req_i,
  input  logic     pd_req_i,
  input  logic     wake_i,
  output pr_mode_e mode_o,
  output logic     inh_o
);
  localparam int SW = (STAB_CLKS > 1) ? $clog2(STAB_CLKS) : 1;
  localparam logic [SW-1:0] STAB_LAST = SW'(STAB_CLKS - 1);

  pr_mode_e      mode_q, mode_d;
  logic [SW-1:0] stab_q, stab_d;
  logic          inh_q, inh_d;

  always_comb begin
    mode_d = mode_q;
    stab_d = stab_q;
    inh_d  = inh_q & rst_sync_i;
    unique case (mode_q)
      MODE_RUN: begin
        if (!rst_sync_i) begin
          if (pd_req_i)        mode_d = MODE_PD;
          else if (idle_req_i) mode_d = MODE_IDLE;
        end
      end
      MODE_IDLE: begin
        if (rst_sync_i) begin
          mode_d = MODE_RUN;
          inh_d  = 1'b1;
        end else if (wake_i) begin
          mode_d = MODE_RUN;
        end
      end
      MODE_PD: begin
        if (rst_sync_i) begin
          mode_d = MODE_STAB;
          stab_d = '0;
        end
      end
      MODE_STAB: begin
        if (stab_q == STAB_LAST) mode_d = MODE_RUN;
        else                     stab_d = stab_q + 1'b1;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      stab_q <= '0;
      inh_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      stab_q <= stab_d;
      inh_q  <= inh_d;
    end
  end

  assign mode_o = mode_q;
  assign inh_o  = inh_q;
endmodule

// File: rtl/pwr_rst_ctrl.sv
`timescale 1ns/1ps
module pwr_rst_ctrl
  import pr_pkg::*;
#(
  parameter int OSC_PER_MC  = 12,
  parameter int QUAL_MC     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int STAB_CLKS   = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_pin_i,
  input  logic idle_req_i,
  input  logic pd_req_i,
  input  logic wake_irq_i,
  output logic mc_stb_o,
  output logic cpu_clk_en_o,
  output logic per_clk_en_o,
  output logic osc_en_o,
  output logic core_rst_o,
  output logic port_ones_o,
  output logic ram_wr_inhibit_o
);
  localparam int QUAL_CLKS = QUAL_MC * OSC_PER_MC;

  logic     rst_sync;
  logic     qual_done;
  logic     osc_run;
  logic     inh;
  pr_mode_e mode;

  pr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rst_pin_i),
    .q_o   (rst_sync)
  );

  pr_mcycle #(.OSC_PER_MC(OSC_PER_MC)) u_mcycle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (osc_run),
    .stb_o (mc_stb_o)
  );

  pr_rst_qual #(.LIMIT(QUAL_CLKS)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (osc_run),
    .pin_i (rst_sync),
    .done_o(qual_done)
  );

  pr_mode_fsm #(.STAB_CLKS(STAB_CLKS)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_sync_i(rst_sync),
    .idle_req_i(idle_req_i),
    .pd_req_i  (pd_req_i),
    .wake_i    (wake_irq_i),
    .mode_o    (mode),
    .inh_o     (inh)
  );

  assign osc_run          = (mode != MODE_PD);
  assign osc_en_o         = osc_run;
  assign cpu_clk_en_o     = (mode == MODE_RUN);
  assign per_clk_en_o     = (mode == MODE_RUN) || (mode == MODE_IDLE);
  assign core_rst_o       = qual_done || (mode == MODE_STAB);
  // ports go high on the raw pin, ahead of qualification
  assign port_ones_o      = rst_pin_i | core_rst_o;
  assign ram_wr_inhibit_o = inh | core_rst_o;
endmodule

// File: rtl/pr_ctrl_chk.sv
`timescale 1ns/1ps
module pr_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_pin_i,
  input logic rst_sync,
  input logic pd_req_i,
  input logic wake_irq_i,
  input logic mc_stb_o,
  input logic cpu_clk_en_o,
  input logic per_clk_en_o,
  input logic osc_en_o,
  input logic core_rst_o,
  input logic port_ones_o,
  input logic ram_wr_inhibit_o
);
  // R1
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_stb_o |=> !mc_stb_o);

  // R2
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> $past(rst_sync));

  // R3
  port_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_i |-> port_ones_o);

  // R5
  idle_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_clk_en_o && !cpu_clk_en_o && wake_irq_i && !rst_sync) |=> cpu_clk_en_o);

  // R6
  pd_no_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !mc_stb_o);

  // R7
  pd_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && !rst_sync) |=> !osc_en_o);

  // R8
  idle_rst_inh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_clk_en_o && !cpu_clk_en_o && rst_sync) |=> (cpu_clk_en_o && ram_wr_inhibit_o));

  // R9
  pd_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && !rst_sync && !core_rst_o && pd_req_i) |=> (!osc_en_o && !per_clk_en_o));
endmodule

bind pwr_rst_ctrl pr_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rst_pin_i       (rst_pin_i),
  .rst_sync        (rst_sync),
  .pd_req_i        (pd_req_i),
  .wake_irq_i      (wake_irq_i),
  .mc_stb_o        (mc_stb_o),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .per_clk_en_o    (per_clk_en_o),
  .osc_en_o        (osc_en_o),
  .core_rst_o      (core_rst_o),
  .port_ones_o     (port_ones_o),
  .ram_wr_inhibit_o(ram_wr_inhibit_o)
);

// File: tb/pwr_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_rst_ctrl_tb_top;
  localparam int STAB = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rst_pin_i = 1'b0, idle_req_i = 1'b0, pd_req_i = 1'b0, wake_irq_i = 1'b0;
  logic mc_stb_o, cpu_clk_en_o, per_clk_en_o, osc_en_o;
  logic core_rst_o, port_ones_o, ram_wr_inhibit_o;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pwr_rst_ctrl #(.STAB_CLKS(STAB)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rst_pin_i(rst_pin_i),
    .idle_req_i(idle_req_i), .pd_req_i(pd_req_i), .wake_irq_i(wake_irq_i),
    .mc_stb_o(mc_stb_o), .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
    .osc_en_o(osc_en_o), .core_rst_o(core_rst_o), .port_ones_o(port_ones_o),
    .ram_wr_inhibit_o(ram_wr_inhibit_o)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_req(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(posedge clk) #1;
    sig = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R2", "core_rst after por", core_rst_o, 0);
    check("R4", "cpu_clk_en after por", cpu_clk_en_o, 1);
    check("R4", "per_clk_en after por", per_clk_en_o, 1);
    check("R6", "osc_en after por", osc_en_o, 1);
    check("R3", "port_ones after por", port_ones_o, 0);
    check("R8", "ram_inhibit after por", ram_wr_inhibit_o, 0);
  endtask

  task automatic t_strobe();
    int gap;
    while (!mc_stb_o) tick(1);
    for (int p = 0; p < 3; p++) begin
      gap = 0;
      do begin tick(1); gap++; end while (!mc_stb_o && gap < 40);
      check("R1", "strobe gap", gap, 12);
    end
  endtask

  task automatic t_short_pulse();
    int seen = 0;
    @(negedge clk) rst_pin_i = 1'b1;
    for (int i = 0; i < 20; i++) begin tick(1); if (core_rst_o) seen = 1; end
    @(negedge clk) rst_pin_i = 1'b0;
    for (int i = 0; i < 4; i++) begin tick(1); if (core_rst_o) seen = 1; end
    check("R2", "short pulse core_rst", seen, 0);
  endtask

  task automatic t_qualify();
    @(negedge clk) rst_pin_i = 1'b1;
    #1 check("R3", "port_ones before edge", port_ones_o, 1);
    tick(3);
    pulse_req(idle_req_i);
    check("R10", "idle ignored while pin synced", cpu_clk_en_o, 1);
    tick(21);
    check("R2", "core_rst at clock 25", core_rst_o, 0);
    tick(1);
    check("R2", "core_rst at clock 26", core_rst_o, 1);
    check("R3", "port_ones in core reset", port_ones_o, 1);
    check("R8", "ram_inhibit in core reset", ram_wr_inhibit_o, 1);
    pulse_req(pd_req_i);
    check("R10", "pd ignored in core reset", osc_en_o, 1);
    @(negedge clk) rst_pin_i = 1'b0;
    tick(2);
    check("R2", "core_rst 2 clocks after release", core_rst_o, 1);
    tick(1);
    check("R2", "core_rst 3 clocks after release", core_rst_o, 0);
    check("R3", "port_ones after release", port_ones_o, 0);
  endtask

  task automatic t_idle_wake();
    pulse_req(idle_req_i);
    check("R4", "idle cpu_clk_en", cpu_clk_en_o, 0);
    check("R4", "idle per_clk_en", per_clk_en_o, 1);
    check("R4", "idle osc_en", osc_en_o, 1);
    tick(5);
    check("R4", "idle held", cpu_clk_en_o, 0);
    pulse_req(wake_irq_i);
    check("R5", "wake cpu_clk_en", cpu_clk_en_o, 1);
  endtask

  task automatic t_idle_reset();
    pulse_req(idle_req_i);
    @(negedge clk) rst_pin_i = 1'b1;
    tick(2);
    check("R8", "idle before sync", cpu_clk_en_o, 0);
    tick(1);
    check("R8", "cpu runs in window", cpu_clk_en_o, 1);
    check("R8", "inhibit in window", ram_wr_inhibit_o, 1);
    check("R8", "core_rst not yet", core_rst_o, 0);
    tick(22);
    check("R8", "inhibit held", ram_wr_inhibit_o, 1);
    check("R2", "core_rst clock 25 idle", core_rst_o, 0);
    tick(1);
    check("R2", "core_rst clock 26 idle", core_rst_o, 1);
    @(negedge clk) rst_pin_i = 1'b0;
    tick(3);
    check("R8", "inhibit cleared", ram_wr_inhibit_o, 0);
  endtask

  task automatic pd_exit_check();
    int stb = 0;
    pulse_req(wake_irq_i);
    for (int i = 0; i < 30; i++) begin tick(1); if (mc_stb_o) stb++; end
    check("R6", "no strobes in pd", stb, 0);
    check("R6", "wake ignored osc", osc_en_o, 0);
    check("R6", "wake ignored cpu", cpu_clk_en_o, 0);
    @(negedge clk) rst_pin_i = 1'b1;
    tick(2);
    check("R7", "osc off before sync", osc_en_o, 0);
    tick(1);
    check("R7", "osc restarted", osc_en_o, 1);
    check("R7", "core_rst on restart", core_rst_o, 1);
    @(negedge clk) rst_pin_i = 1'b0;
    tick(10);
    check("R7", "core_rst held for settle", core_rst_o, 1);
    tick(STAB);
    check("R7", "core_rst after settle", core_rst_o, 0);
    check("R7", "cpu runs after settle", cpu_clk_en_o, 1);
  endtask

  task automatic t_pd();
    pulse_req(pd_req_i);
    check("R6", "pd osc_en", osc_en_o, 0);
    check("R6", "pd cpu_clk_en", cpu_clk_en_o, 0);
    check("R6", "pd per_clk_en", per_clk_en_o, 0);
    pd_exit_check();
  endtask

  task automatic t_priority();
    @(negedge clk) begin idle_req_i = 1'b1; pd_req_i = 1'b1; end
    @(posedge clk) #1;
    idle_req_i = 1'b0; pd_req_i = 1'b0;
    check("R9", "pd wins osc_en", osc_en_o, 0);
    check("R9", "pd wins per_clk_en", per_clk_en_o, 0);
    pd_exit_check();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    @(negedge clk) rst_ni = 1'b1;
    tick(1);
    t_reset_state();
    t_strobe();
    t_short_pulse();
    t_qualify();
    t_idle_wake();
    t_idle_reset();
    t_pd();
    t_priority();
    t_strobe();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule